// File: doc/BRIEF.md
# Mailbox I2C Bus Master

This block is a single-master I2C controller run entirely through a small set of 16-bit registers. Software first loads the outgoing data register, then writes one command word. That word names a 7-bit target, a direction and a data length of one or two bytes. It also carries two flags: one that keeps the bus after the command and one that asks for the address phase only. The block then generates the START (or repeated START), address byte, data bytes, acknowledge bits and, unless asked to keep the bus, the closing STOP. It drives SCL and SDA as open-drain pull-down enables.

When a command ends, one of three event bits is raised in a status register: write done, read done or error. Bytes received from the target are placed in the incoming data register. While a command is running, a busy flag is set and further command writes are dropped. Software can chain several commands into one bus transaction by setting the keep-bus flag on every command but the last. Each later command then opens with a repeated START. An address-only read serves as a presence probe for a target.

Top module: `i2c_mbox_master`

## Requirements
- R1: A command write is accepted only when command bits 15:14 equal 2'b10 and the block is not busy; a word with any other value there starts nothing and changes no status bit.
- R2: Every command begins with START, then sends the address byte MSB first: command bits 7:1 as the 7-bit target address, followed by the direction bit, which is 0 when command bit 10 is set (write) and 1 when it is clear (read).
- R3: Command bit 11 clear moves one data byte and set moves two; on a write the outgoing register bits 7:0 are sent first and bits 15:8 second, and a successful write sets status bit 14.
- R4: On a read the first received byte lands in incoming register bits 7:0 and the second in bits 15:8; an accepted read clears the incoming register, so a one-byte read leaves bits 15:8 at zero; a successful read sets status bit 15.
- R5: During a read the master ACKs every received byte except the last, which it NACKs.
- R6: Command bit 13 set ends the command without STOP: SCL is held low, busy drops, the completion bit is set, and the next accepted command starts with a repeated START; with bit 13 clear the command ends with STOP.
- R7: Status bits are 13 (error), 14 (write done) and 15 (read done); writing 1 to a bit through the status-clear port clears it, writing 0 leaves it.
- R8: A NACK on the address byte or on any written data byte stops the command, issues a STOP and sets status bit 13 and no completion bit.
- R9: Command bit 12 set with bit 10 clear is a probe: only START, address byte and STOP occur, status bit 15 is set on ACK and bit 13 on NACK.
- R10: Busy is high from the cycle after acceptance until the command completes; command writes made while busy are ignored.
- R11: One SCL period lasts 4*CLK_DIV clock cycles, and during data and acknowledge bits SDA changes only while SCL is low.
- R12: After reset both bus lines are released, busy is low and both the status and incoming data registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 16 | Command word |
| wext_we | input | 1 | Outgoing data register write strobe |
| wext_data | input | 16 | Outgoing data bytes (low byte first on the bus) |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_data | input | 16 | Write-one-to-clear mask for the status bits |
| rext_data | output | 16 | Incoming data register |
| stat_data | output | 16 | Status register (bits 13, 14, 15) |
| busy | output | 1 | Command in progress |
| sda_in | input | 1 | Sampled SDA line level, synchronous to clk |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A behavioural target on the wired-AND bus answers at one fixed address. It logs the bytes it receives, the ACK or NACK it gets on each byte it sends, and every START and STOP. Directed cases cover one- and two-byte writes and reads, an address NACK versus a data NACK (which differ in how many bytes reach the target), probes to present and absent targets, a command dropped while busy, rejected mode values, and a kept bus followed by a read (one STOP across two STARTs). Random commands then mix direction, length, data and matching or non-matching addresses. These separate the byte order, the ACK pattern and the choice of status bit from one another.

// File: rtl/i2cm_pkg.sv
// Shared field positions, command record and sequencer states for the
// mailbox I2C master. Assumes a 16-bit register width throughout.
package i2cm_pkg;
    localparam int REG_W          = 16;
    localparam int ADDR_W         = 7;
    localparam int BYTE_W         = 8;
    localparam int CMD_ADDR_LSB   = 1;
    localparam int CMD_WRITE_BIT  = 10;
    localparam int CMD_TWO_BIT    = 11;
    localparam int CMD_PROBE_BIT  = 12;
    localparam int CMD_HOLD_BIT   = 13;
    localparam int CMD_MODE_LSB   = 14;
    localparam logic [1:0] CMD_MODE_NATIVE = 2'b10;
    localparam int ST_ERR_BIT     = 13;
    localparam int ST_TX_BIT      = 14;
    localparam int ST_RX_BIT      = 15;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              is_write;
        logic              two_byte;
        logic              probe;
        logic              hold;
    } cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_BITS,
        SQ_STOP,
        SQ_HELD
    } sq_state_t;
endpackage

// File: rtl/i2cm_tick.sv
// Free-running divider: emits a one-cycle tick every CLK_DIV clocks.
// Each tick advances the bus sequencer by one quarter of a bit.
// Assumes CLK_DIV >= 1.
module i2cm_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    // count clocks within one quarter-bit
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/i2cm_cmd_decode.sv
// Splits a 16-bit command word into its fields and flags whether the
// mode field holds the only accepted value. Pure combinational.
module i2cm_cmd_decode
    import i2cm_pkg::*;
(
    input  logic [REG_W-1:0] word,
    output cmd_t             cmd,
    output logic             ok
);
    logic unused_bits;
    assign unused_bits = ^{word[0], word[9:8]};

    // field extraction and mode check
    always_comb begin
        cmd.addr     = word[CMD_ADDR_LSB +: ADDR_W];
        cmd.is_write = word[CMD_WRITE_BIT];
        cmd.two_byte = word[CMD_TWO_BIT];
        cmd.probe    = word[CMD_PROBE_BIT];
        cmd.hold     = word[CMD_HOLD_BIT];
        ok           = (word[CMD_MODE_LSB +: 2] == CMD_MODE_NATIVE);
    end
endmodule

// File: rtl/i2cm_bitseq.sv
// Bus sequencer: runs START, address byte, up to two data bytes with
// acknowledge bits, then STOP or a held state. Each bit takes four
// ticks: SCL low (SDA set), SCL high, SCL high (sample), SCL low.
// Assumes sda_in is already synchronous to clk and that no other master
// or clock stretching is present.
module i2cm_bitseq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  cmd_t              cmd_in,
    input  logic [REG_W-1:0]  wdata_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              busy,
    output logic              held,
    output logic              rx_we,
    output logic              rx_hi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ev_tx,
    output logic              ev_rx,
    output logic              ev_err
);
    localparam logic [3:0] ACK_IDX = 4'(BYTE_W);

    sq_state_t          state;
    logic [1:0]         phase;
    logic [3:0]         bit_idx;
    logic [1:0]         byte_idx;
    logic [BYTE_W-1:0]  tx_sh;
    logic [BYTE_W-1:0]  rx_sh;
    logic               ack_smp;
    logic               err_q;
    cmd_t               cmd_q;
    logic [REG_W-1:0]   wdata_q;

    logic [1:0] n_data;
    logic       is_tx_byte;
    logic       last_byte;
    logic       drive_bit;

    // per-byte context derived from the latched command
    always_comb begin
        n_data     = cmd_q.probe ? 2'd0 : (cmd_q.two_byte ? 2'd2 : 2'd1);
        is_tx_byte = (byte_idx == 2'd0) || cmd_q.is_write;
        last_byte  = (byte_idx == n_data);
        if (bit_idx != ACK_IDX) drive_bit = is_tx_byte ? tx_sh[BYTE_W-1] : 1'b1;
        else                    drive_bit = is_tx_byte ? 1'b1 : last_byte;
    end

    // bus sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            phase    <= 2'd0;
            bit_idx  <= 4'd0;
            byte_idx <= 2'd0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            ack_smp  <= 1'b0;
            err_q    <= 1'b0;
            cmd_q    <= '0;
            wdata_q  <= '0;
            rx_we    <= 1'b0;
            rx_hi    <= 1'b0;
            rx_byte  <= '0;
            ev_tx    <= 1'b0;
            ev_rx    <= 1'b0;
            ev_err   <= 1'b0;
        end else begin
            rx_we  <= 1'b0;
            ev_tx  <= 1'b0;
            ev_rx  <= 1'b0;
            ev_err <= 1'b0;
            if (start) begin
                state   <= SQ_START;
                phase   <= 2'd0;
                err_q   <= 1'b0;
                cmd_q   <= cmd_in;
                wdata_q <= wdata_in;
            end else if (tick && busy) begin
                phase <= phase + 2'd1;
                unique case (state)
                    SQ_START: begin
                        if (phase == 2'd3) begin
                            state    <= SQ_BITS;
                            bit_idx  <= 4'd0;
                            byte_idx <= 2'd0;
                            tx_sh    <= {cmd_q.addr, ~cmd_q.is_write};
                        end
                    end
                    SQ_BITS: begin
                        if (phase == 2'd2) begin
                            if (bit_idx != ACK_IDX) rx_sh   <= {rx_sh[BYTE_W-2:0], sda_in};
                            else                    ack_smp <= sda_in;
                        end
                        if (phase == 2'd3) begin
                            if (bit_idx != ACK_IDX) begin
                                bit_idx <= bit_idx + 4'd1;
                                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            end else begin
                                bit_idx <= 4'd0;
                                if (is_tx_byte && ack_smp) begin
                                    state <= SQ_STOP;
                                    err_q <= 1'b1;
                                end else begin
                                    if (!is_tx_byte) begin
                                        rx_we   <= 1'b1;
                                        rx_hi   <= (byte_idx == 2'd2);
                                        rx_byte <= rx_sh;
                                    end
                                    if (last_byte) begin
                                        if (cmd_q.hold) begin
                                            state <= SQ_HELD;
                                            ev_tx <= cmd_q.is_write;
                                            ev_rx <= ~cmd_q.is_write;
                                        end else begin
                                            state <= SQ_STOP;
                                        end
                                    end else begin
                                        byte_idx <= byte_idx + 2'd1;
                                        tx_sh    <= (byte_idx == 2'd0) ? wdata_q[BYTE_W-1:0]
                                                                       : wdata_q[REG_W-1:BYTE_W];
                                    end
                                end
                            end
                        end
                    end
                    SQ_STOP: begin
                        if (phase == 2'd3) begin
                            state  <= SQ_IDLE;
                            ev_err <= err_q;
                            ev_tx  <= ~err_q & cmd_q.is_write;
                            ev_rx  <= ~err_q & ~cmd_q.is_write;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // open-drain drive of both lines per state and quarter-bit
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        unique case (state)
            SQ_START: begin
                scl_pull = (phase == 2'd0) || (phase == 2'd3);
                sda_pull = (phase >= 2'd2);
            end
            SQ_BITS: begin
                scl_pull = (phase == 2'd0) || (phase == 2'd3);
                sda_pull = ~drive_bit;
            end
            SQ_STOP: begin
                scl_pull = (phase == 2'd0);
                sda_pull = (phase <= 2'd1);
            end
            SQ_HELD: scl_pull = 1'b1;
            default: ;
        endcase
    end

    assign busy = (state != SQ_IDLE) && (state != SQ_HELD);
    assign held = (state == SQ_HELD);

    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_BITS && $past(state) == SQ_BITS && !scl_pull && !$past(scl_pull))
        |-> $stable(sda_pull)); // R11

    AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == SQ_IDLE || state == SQ_HELD)); // R10
endmodule

// File: rtl/i2c_mbox_master.sv
// Top of the mailbox I2C master: holds the outgoing and incoming data
// registers and the write-one-to-clear status register, accepts command
// words and hands them to the bus sequencer. Assumes sda_in is already
// synchronised to clk by the surrounding logic.
module i2c_mbox_master
    import i2cm_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [15:0] cmd_data,
    input  logic        wext_we,
    input  logic [15:0] wext_data,
    input  logic        stat_clr_we,
    input  logic [15:0] stat_clr_data,
    output logic [15:0] rext_data,
    output logic [15:0] stat_data,
    output logic        busy,
    input  logic        sda_in,
    output logic        scl_pull,
    output logic        sda_pull
);
    cmd_t               dec_cmd;
    logic               dec_ok;
    logic               tick;
    logic               accept;
    logic               seq_busy;
    logic               held;
    logic               rx_we;
    logic               rx_hi;
    logic [BYTE_W-1:0]  rx_byte;
    logic               ev_tx;
    logic               ev_rx;
    logic               ev_err;
    logic [REG_W-1:0]   wext_q;
    logic [REG_W-1:0]   rext_q;
    logic [2:0]         stat_q;   // {rx, tx, err}
    logic [2:0]         clr_mask;
    logic               unused_clr;

    assign unused_clr = ^stat_clr_data[ST_ERR_BIT-1:0];

    i2cm_cmd_decode u_dec (
        .word (cmd_data),
        .cmd  (dec_cmd),
        .ok   (dec_ok)
    );

    i2cm_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign accept = cmd_we && dec_ok && !seq_busy;

    i2cm_bitseq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (accept),
        .cmd_in   (dec_cmd),
        .wdata_in (wext_q),
        .sda_in   (sda_in),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .busy     (seq_busy),
        .held     (held),
        .rx_we    (rx_we),
        .rx_hi    (rx_hi),
        .rx_byte  (rx_byte),
        .ev_tx    (ev_tx),
        .ev_rx    (ev_rx),
        .ev_err   (ev_err)
    );

    // outgoing data register
    always_ff @(posedge clk) begin
        if (!rst_n)       wext_q <= '0;
        else if (wext_we) wext_q <= wext_data;
    end

    // incoming data register: cleared on read accept, filled per byte
    always_ff @(posedge clk) begin
        if (!rst_n)                           rext_q <= '0;
        else if (accept && !dec_cmd.is_write) rext_q <= '0;
        else if (rx_we && rx_hi)              rext_q[REG_W-1:BYTE_W] <= rx_byte;
        else if (rx_we)                       rext_q[BYTE_W-1:0] <= rx_byte;
    end

    assign clr_mask = stat_clr_we ? stat_clr_data[ST_RX_BIT:ST_ERR_BIT] : 3'b000;

    // status register: new events win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 3'b000;
        else        stat_q <= (stat_q & ~clr_mask) | {ev_rx, ev_tx, ev_err};
    end

    assign stat_data = {stat_q, {ST_ERR_BIT{1'b0}}};
    assign rext_data = rext_q;
    assign busy      = seq_busy;

    AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_we && stat_clr_data[ST_ERR_BIT] && !ev_err) |=> !stat_data[ST_ERR_BIT]); // R7

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_err, ev_tx, ev_rx})); // R8

    AST_BUS_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !held) |-> (!scl_pull && !sda_pull)); // R12
endmodule

// File: tb/sim_i2c_mbox_master.sv
module sim_i2c_mbox_master;
    localparam int CLK_DIV = 4;
    localparam logic [6:0] SLV = 7'h3A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        wext_we = 1'b0;
    logic [15:0] wext_data = '0;
    logic        stat_clr_we = 1'b0;
    logic [15:0] stat_clr_data = '0;
    logic [15:0] rext_data;
    logic [15:0] stat_data;
    logic        busy;
    logic        scl_pull;
    logic        sda_pull;

    // target model state (written only by the target process)
    logic        s_pull = 1'b0;
    wire         scl_ln = ~scl_pull;
    wire         sda_ln = ~(sda_pull | s_pull);

    always #5 clk = ~clk;

    i2c_mbox_master #(.CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .wext_we(wext_we), .wext_data(wext_data),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
        .rext_data(rext_data), .stat_data(stat_data), .busy(busy),
        .sda_in(sda_ln), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench-owned target configuration
    logic [7:0] rsrc [0:3];
    int         nack_at = -1;

    // target-owned observations
    int         start_cnt = 0, stop_cnt = 0;
    logic [7:0] wlog [0:3];
    int         wlog_n = 0;
    logic       mlog [0:3];
    int         mlog_n = 0;
    logic [7:0] addr_byte = '0;
    int         gap = 0;
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic       s_act = 0, s_first = 0, s_tx = 0, s_done = 0, s_match = 0, s_rw = 0, m_nack = 0;
    int         s_bc = 0, dcnt = 0, r_idx = 0, rise_cyc = 0;
    logic [7:0] sh = '0, sb = '0;

    // behavioural target on the wired-AND bus, single process
    always @(scl_ln or sda_ln) begin
        if (scl_ln === 1'b1 && p_scl === 1'b1 && p_sda === 1'b1 && sda_ln === 1'b0) begin
            start_cnt++; s_act = 1; s_bc = 0; s_first = 1; s_tx = 0; s_done = 0;
            s_pull = 0; dcnt = 0; wlog_n = 0; mlog_n = 0;
        end else if (scl_ln === 1'b1 && p_scl === 1'b1 && p_sda === 1'b0 && sda_ln === 1'b1) begin
            stop_cnt++; s_act = 0; s_pull = 0;
        end else if (p_scl === 1'b0 && scl_ln === 1'b1) begin
            if (s_act) begin
                if (s_bc >= 1 && s_bc <= 7) gap = cyc - rise_cyc;
                rise_cyc = cyc;
                if (s_bc < 8) begin
                    if (!s_tx) sh = {sh[6:0], sda_ln};
                end else if (s_tx) m_nack = sda_ln;
                s_bc = (s_bc == 8) ? 0 : s_bc + 1;
            end
        end else if (p_scl === 1'b1 && scl_ln === 1'b0) begin
            if (s_act) begin
                if (s_bc == 8) begin
                    s_done = 1;
                    if (!s_tx) begin
                        if (s_first) begin
                            addr_byte = sh; s_match = (sh[7:1] == SLV); s_rw = sh[0];
                            s_pull = s_match;
                        end else begin
                            wlog[wlog_n[1:0]] = sh; wlog_n++;
                            s_pull = (dcnt != nack_at); dcnt++;
                        end
                    end else s_pull = 0;
                end else if (s_bc == 0 && s_done) begin
                    s_done = 0; s_pull = 0;
                    if (s_first) begin
                        s_first = 0;
                        if (!s_match) s_act = 0;
                        else begin
                            s_tx = s_rw;
                            if (s_tx) begin sb = rsrc[0]; r_idx = 1; s_pull = ~sb[7]; end
                        end
                    end else if (s_tx) begin
                        mlog[mlog_n[1:0]] = m_nack; mlog_n++;
                        if (!m_nack) begin sb = rsrc[r_idx[1:0]]; r_idx++; s_pull = ~sb[7]; end
                        else s_act = 0;
                    end
                end else if (s_tx && s_bc >= 1 && s_bc <= 7) begin
                    sb = {sb[6:0], 1'b0}; s_pull = ~sb[7];
                end
            end
        end
        p_scl = scl_ln;
        p_sda = sda_ln;
    end

    function automatic logic [15:0] mk(input logic [6:0] a, input bit wr, input bit two,
                                       input bit hold, input bit probe);
        return {2'b10, hold, probe, two, wr, 2'b00, a, 1'b0};
    endfunction

    function automatic logic [15:0] exp_stat(input bit ok, input bit wr);
        if (!ok) return 16'h2000;
        return wr ? 16'h4000 : 16'h8000;
    endfunction

    function automatic logic [15:0] exp_rext(input bit two, input logic [7:0] b0, input logic [7:0] b1);
        return two ? {b1, b0} : {8'h00, b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] w);
        @(negedge clk); cmd_data = w; cmd_we = 1'b1;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic set_wext(input logic [15:0] v);
        @(negedge clk); wext_data = v; wext_we = 1'b1;
        @(negedge clk); wext_we = 1'b0;
    endtask

    task automatic clr_stat(input logic [15:0] m);
        @(negedge clk); stat_clr_data = m; stat_clr_we = 1'b1;
        @(negedge clk); stat_clr_we = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (stat_data[15:13] == 3'b000 && n < 8000) begin @(negedge clk); n++; end
        if (n >= 8000) chk({tag, " timeout"}, 1, 0);
    endtask

    int s0, p0;

    initial begin
        void'($urandom(32'd4242));
        rsrc[0] = 8'h81; rsrc[1] = 8'h7E; rsrc[2] = 8'hFF; rsrc[3] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 busy", busy, 0);
        chk("R12 scl", scl_pull, 0);
        chk("R12 sda", sda_pull, 0);
        chk("R12 stat", stat_data, 0);
        chk("R12 rext", rext_data, 0);

        // R3 two-byte write, byte order; R2 address byte; R11 bit period
        set_wext(16'h3CA5);
        p0 = stop_cnt;
        issue(mk(SLV, 1, 1, 0, 0));
        wait_done("R3");
        chk("R3 stat", stat_data, exp_stat(1, 1));
        chk("R3 count", wlog_n, 2);
        chk("R3 first byte", wlog[0], 8'hA5);
        chk("R3 second byte", wlog[1], 8'h3C);
        chk("R2 write addr byte", addr_byte, {SLV, 1'b0});
        chk("R11 period", gap, 4 * CLK_DIV);
        chk("R6 stop issued", stop_cnt - p0, 1);
        clr_stat(16'h4000);
        chk("R7 cleared", stat_data, 0);

        // R4 R5 two-byte read
        issue(mk(SLV, 0, 1, 0, 0));
        wait_done("R4");
        chk("R4 stat", stat_data, exp_stat(1, 0));
        chk("R4 rext", rext_data, exp_rext(1, 8'h81, 8'h7E));
        chk("R2 read addr byte", addr_byte, {SLV, 1'b1});
        chk("R5 count", mlog_n, 2);
        chk("R5 ack first", mlog[0], 0);
        chk("R5 nack last", mlog[1], 1);
        clr_stat(16'h0000);
        chk("R7 zero mask keeps", stat_data, 16'h8000);
        clr_stat(16'hE000);

        // R4 one-byte read clears upper byte
        rsrc[0] = 8'h5C;
        issue(mk(SLV, 0, 0, 0, 0));
        wait_done("R4b");
        chk("R4 one-byte rext", rext_data, exp_rext(0, 8'h5C, 8'h00));
        chk("R5 single nack", mlog[0], 1);
        clr_stat(16'hE000);

        // R8 address NACK
        p0 = stop_cnt;
        issue(mk(SLV ^ 7'h01, 1, 1, 0, 0));
        wait_done("R8a");
        chk("R8 addr nack stat", stat_data, 16'h2000);
        chk("R8 addr nack stop", stop_cnt - p0, 1);
        clr_stat(16'hE000);

        // R8 data NACK on first written byte
        nack_at = 0;
        issue(mk(SLV, 1, 1, 0, 0));
        wait_done("R8d");
        chk("R8 data nack stat", stat_data, 16'h2000);
        chk("R8 data nack bytes", wlog_n, 1);
        nack_at = -1;
        clr_stat(16'hE000);

        // R9 probe; the target returns all-ones so it leaves SDA released
        rsrc[0] = 8'hFF;
        issue(mk(SLV, 0, 0, 0, 1));
        wait_done("R9");
        chk("R9 probe present", stat_data, 16'h8000);
        chk("R9 no data byte", mlog_n, 0);
        clr_stat(16'hE000);
        issue(mk(SLV ^ 7'h10, 0, 0, 0, 1));
        wait_done("R9n");
        chk("R9 probe absent", stat_data, 16'h2000);
        clr_stat(16'hE000);

        // R10 command ignored while busy
        s0 = start_cnt;
        issue(mk(SLV, 1, 1, 0, 0));
        repeat (40) @(negedge clk);
        chk("R10 busy", busy, 1);
        issue(mk(SLV, 0, 0, 0, 0));
        wait_done("R10");
        repeat (300) @(negedge clk);
        chk("R10 one start", start_cnt - s0, 1);
        chk("R10 stat", stat_data, 16'h4000);
        chk("R10 idle", busy, 0);
        clr_stat(16'hE000);

        // R1 rejected mode values
        s0 = start_cnt;
        issue(mk(SLV, 1, 0, 0, 0) ^ 16'hC000);
        issue(mk(SLV, 1, 0, 0, 0) | 16'hC000);
        repeat (100) @(negedge clk);
        chk("R1 no busy", busy, 0);
        chk("R1 no start", start_cnt - s0, 0);
        chk("R1 no status", stat_data, 0);

        // R6 held bus then repeated START read
        set_wext(16'h0055);
        s0 = start_cnt; p0 = stop_cnt;
        issue(mk(SLV, 1, 0, 1, 0));
        wait_done("R6");
        chk("R6 stat", stat_data, 16'h4000);
        chk("R6 no stop", stop_cnt - p0, 0);
        chk("R6 scl held low", scl_pull, 1);
        chk("R6 not busy", busy, 0);
        chk("R6 byte", wlog[0], 8'h55);
        clr_stat(16'hE000);
        rsrc[0] = 8'h12; rsrc[1] = 8'h34;
        issue(mk(SLV, 0, 1, 0, 0));
        wait_done("R6r");
        chk("R6 restart count", start_cnt - s0, 2);
        chk("R6 one stop", stop_cnt - p0, 1);
        chk("R6 read stat", stat_data, 16'h8000);
        chk("R6 read data", rext_data, 16'h3412);
        clr_stat(16'hE000);

        // random mix of R2 R3 R4 R8
        for (int i = 0; i < 24; i++) begin
            bit match = ($urandom % 5) != 0;
            bit wr = $urandom % 2;
            bit two = $urandom % 2;
            logic [6:0] a = match ? SLV : (SLV ^ 7'(($urandom % 127) + 1));
            logic [15:0] wd = 16'($urandom);
            rsrc[0] = 8'($urandom); rsrc[1] = 8'($urandom);
            if (wr) set_wext(wd);
            issue(mk(a, wr, two, 0, 0));
            wait_done("rnd");
            chk("R8 rnd stat", stat_data, exp_stat(match, wr));
            if (match && wr) begin
                chk("R3 rnd b0", wlog[0], wd[7:0]);
                if (two) chk("R3 rnd b1", wlog[1], wd[15:8]);
            end
            if (match && !wr) chk("R4 rnd rext", rext_data, exp_rext(two, rsrc[0], rsrc[1]));
            clr_stat(16'hE000);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule